// File: doc/BRIEF.md
# Shared Interrupt Affinity Routing Table

This block keeps one 64-bit routing register for each shared peripheral interrupt and turns the affinity value programmed into it into a local CPU number. A CPU-table port gives the affinity of every CPU slot and says which slots are present. When software writes a routing word, the block compares the new affinity against all present CPUs at once. It then records the target CPU index, or a reserved marker when no CPU matches. It also moves the interrupt's bit between per-CPU target bitmaps.

Software reaches the routing words through a word-addressed register port. Interrupt number N has its lower word at word address 2N and its upper word at 2N+1. Shared interrupts start at number 32, so the first routing word lies 0x100 bytes above the routing base. Pending and delivery logic sit elsewhere and read the target index, its valid flag and the per-CPU bitmaps. A value that names no CPU is still stored and reads back as written. Its interrupt may become pending but is never handed to any CPU.

Top module: `spi_route_table`

## Requirements
- R1: A word address w selects interrupt number w>>1 and shared index (w>>1)-32. Only numbers 32 up to 32+NUM_SPI-1 are routed. Reads of any other number return 0, and writes to them change no output.
- R2: The upper word of a routing register (odd w) always reads 0, and writes to it change no output.
- R3: A lower-word write stores bits [23:0] of the write data and drops bits [31:24]. A read of the lower word returns {8'h00, stored[23:0]}, whether or not the value names a CPU.
- R4: After reset every shared interrupt stores CPU slot 0's table entry and has target index 0 with valid high. The bitmap of CPU 0 has all NUM_SPI bits set, and every other bitmap is zero.
- R5: If the new stored value (top byte zero) equals the table entry of a present CPU, the target index becomes the lowest such slot and valid goes high. That CPU's bitmap gets the interrupt's bit.
- R6: If the new stored value matches no present CPU, the target index becomes 8'hFF with valid low, and no bitmap holds the interrupt's bit.
- R7: On a routing write, the interrupt's bit is first cleared from the bitmap of the present CPU whose entry equals the previously stored value. The new value is stored after that.
- R8: A CPU slot whose present flag is low never matches, even if its table entry equals the written value.
- R9: route_upd is high for exactly the one cycle after each accepted lower-word write inside the routed range, and low in every other cycle.
- R10: Read data appears in the same cycle as the access request and is 0 when no read is requested. A write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Register access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Word address relative to the routing base |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (combinational) |
| cpu_aff | input | NUM_CPU*32 | Compact affinity of each CPU slot, slot c at [32c+31:32c] |
| cpu_present | input | NUM_CPU | Slot c holds an existing CPU |
| spi_tgt | output | NUM_SPI*8 | Target CPU index per shared interrupt, 8'hFF = none |
| spi_tgt_vld | output | NUM_SPI | Target index names a CPU |
| cpu_spi_map | output | NUM_CPU*NUM_SPI | Bitmap of shared interrupts per CPU, CPU c at [NUM_SPI*c +: NUM_SPI] |
| route_upd | output | 1 | State-update pulse after a routing write |

## Verification
The bench builds the block with NUM_SPI=8, NUM_CPU=4 and ADDR_W=8. This brings both ends of the routed range (numbers 31, 32, 39 and 40) within a few word addresses. In the CPU table, slot 2 is absent and slot 3 repeats slot 1's affinity, so the absent-CPU case and the lowest-slot priority are both reachable. Written values that drop a nonzero top byte, values that name no CPU, and moves of an interrupt from one owner back to another check the clear-then-set order.

// File: rtl/spi_route_pkg.sv
package spi_route_pkg;

    localparam int unsigned AFF_W        = 32;
    localparam int unsigned IDX_W        = 8;
    localparam int unsigned FIRST_SHARED = 32;

    typedef logic [AFF_W-1:0] aff_t;
    typedef logic [IDX_W-1:0] cpu_idx_t;

    // Reserved target value: no CPU owns the interrupt (outside 0..254)
    localparam cpu_idx_t NO_CPU = 8'hFF;

    // Only affinity levels 0..2 can be written through the lower word
    function automatic aff_t keep_written(input logic [31:0] wdata);
        return {8'h00, wdata[23:0]};
    endfunction

    // Read view of a stored value: the level-3 byte belongs to the upper word
    function automatic logic [31:0] low_word_view(input aff_t stored);
        return {8'h00, stored[23:0]};
    endfunction

endpackage

// File: rtl/route_addr_dec.sv
module route_addr_dec
    import spi_route_pkg::*;
#(
    parameter int unsigned NUM_SPI = 32,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned SPI_W  = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic              lo_word,
    output logic [SPI_W-1:0]  spi
);
    logic [31:0] irq_num;

    always_comb begin
        irq_num  = 32'(addr >> 1);
        in_range = (irq_num >= FIRST_SHARED) && (irq_num < FIRST_SHARED + NUM_SPI);
        lo_word  = ~addr[0];
        spi      = SPI_W'(irq_num - FIRST_SHARED);
    end
endmodule

// File: rtl/aff_match.sv
module aff_match
    import spi_route_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4
) (
    input  aff_t                            key,
    input  logic [NUM_CPU-1:0][AFF_W-1:0]   aff_tbl,
    input  logic [NUM_CPU-1:0]              present,
    output logic                            hit,
    output cpu_idx_t                        idx
);
    if (NUM_CPU > 255) begin : g_cpu_limit
        $error("aff_match: NUM_CPU must not exceed 255");
    end

    logic [NUM_CPU-1:0] eq;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cmp
        assign eq[c] = present[c] && (aff_tbl[c] == key);
    end

    always_comb begin
        hit = |eq;
        idx = NO_CPU;
        for (int c = NUM_CPU - 1; c >= 0; c--) begin
            if (eq[c]) idx = cpu_idx_t'(c);
        end
    end
endmodule

// File: rtl/spi_route_table.sv
module spi_route_table
    import spi_route_pkg::*;
#(
    parameter int unsigned NUM_SPI = 32,
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned ADDR_W  = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_en,
    input  logic                       acc_we,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic [31:0]                acc_wdata,
    output logic [31:0]                acc_rdata,
    input  logic [NUM_CPU*AFF_W-1:0]   cpu_aff,
    input  logic [NUM_CPU-1:0]         cpu_present,
    output logic [NUM_SPI*IDX_W-1:0]   spi_tgt,
    output logic [NUM_SPI-1:0]         spi_tgt_vld,
    output logic [NUM_CPU*NUM_SPI-1:0] cpu_spi_map,
    output logic                       route_upd
);
    localparam int unsigned SPI_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;
    localparam int unsigned CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    typedef struct packed {
        logic [NUM_SPI-1:0][AFF_W-1:0]  aff;
        logic [NUM_SPI-1:0][IDX_W-1:0]  tgt;
        logic [NUM_CPU-1:0][NUM_SPI-1:0] map;
        logic                            upd;
    } route_state_t;

    route_state_t s_d, s_q, s_rst;

    logic [NUM_CPU-1:0][AFF_W-1:0] tbl;
    logic                          in_range, lo_word, wr_lo;
    logic [SPI_W-1:0]              spi;
    aff_t                          old_key, new_key;
    logic                          old_hit, new_hit;
    cpu_idx_t                      old_idx, new_idx;

    assign tbl = cpu_aff;

    route_addr_dec #(.NUM_SPI(NUM_SPI), .ADDR_W(ADDR_W)) u_dec (
        .addr     (acc_addr),
        .in_range (in_range),
        .lo_word  (lo_word),
        .spi      (spi)
    );

    assign wr_lo   = acc_en && acc_we && in_range && lo_word;
    assign old_key = s_q.aff[spi];
    assign new_key = keep_written(acc_wdata);

    aff_match #(.NUM_CPU(NUM_CPU)) u_old_owner (
        .key     (old_key),
        .aff_tbl (tbl),
        .present (cpu_present),
        .hit     (old_hit),
        .idx     (old_idx)
    );

    aff_match #(.NUM_CPU(NUM_CPU)) u_new_owner (
        .key     (new_key),
        .aff_tbl (tbl),
        .present (cpu_present),
        .hit     (new_hit),
        .idx     (new_idx)
    );

    // Reset image: everything routed to CPU slot 0
    always_comb begin
        s_rst        = '0;
        s_rst.aff    = {NUM_SPI{tbl[0]}};
        s_rst.map[0] = '1;
    end

    // Next-state: clear previous owner, store, then set new owner
    always_comb begin
        s_d     = s_q;
        s_d.upd = 1'b0;
        if (wr_lo) begin
            if (old_hit) s_d.map[old_idx[CPU_W-1:0]][spi] = 1'b0;
            s_d.aff[spi] = new_key;
            if (new_hit) begin
                s_d.tgt[spi]                       = new_idx;
                s_d.map[new_idx[CPU_W-1:0]][spi] = 1'b1;
            end else begin
                s_d.tgt[spi] = NO_CPU;
            end
            s_d.upd = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= s_rst;
        else        s_q <= s_d;
    end

    always_comb begin
        acc_rdata = '0;
        if (acc_en && !acc_we && in_range && lo_word)
            acc_rdata = low_word_view(s_q.aff[spi]);
    end

    assign spi_tgt     = s_q.tgt;
    assign cpu_spi_map = s_q.map;
    assign route_upd   = s_q.upd;

    for (genvar i = 0; i < NUM_SPI; i++) begin : g_spi
        logic [NUM_CPU-1:0] owners;

        assign spi_tgt_vld[i] = (s_q.tgt[i] != NO_CPU);

        for (genvar c = 0; c < NUM_CPU; c++) begin : g_col
            assign owners[c] = cpu_spi_map[c*NUM_SPI + i];
        end

        // R5
        single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(owners));

        // R5
        owner_matches_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            spi_tgt_vld[i] |-> owners[spi_tgt[i*IDX_W +: CPU_W]]);

        // R6
        unowned_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !spi_tgt_vld[i] |-> (owners == '0));
    end

    // R9
    upd_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> route_upd);

    // R9
    upd_only_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_upd |-> $past(wr_lo));

    // R2
    hi_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && !lo_word) |-> (acc_rdata == 32'h0));

    // R1
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we && !(in_range && lo_word)) |=>
            ($stable(spi_tgt) && $stable(cpu_spi_map)));
endmodule

// File: tb/spi_route_table_test.sv
`timescale 1ns/1ps
module spi_route_table_test;
    localparam int NS = 8;
    localparam int NC = 4;
    localparam int AW = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              acc_en, acc_we;
    logic [AW-1:0]     acc_addr;
    logic [31:0]       acc_wdata, acc_rdata;
    logic [NC*32-1:0]  cpu_aff;
    logic [NC-1:0]     cpu_present;
    logic [NS*8-1:0]   spi_tgt;
    logic [NS-1:0]     spi_tgt_vld;
    logic [NC*NS-1:0]  cpu_spi_map;
    logic              route_upd;

    always #2 clk = ~clk;

    spi_route_table #(.NUM_SPI(NS), .NUM_CPU(NC), .ADDR_W(AW)) uut (
        .clk, .rst_n, .acc_en, .acc_we, .acc_addr, .acc_wdata, .acc_rdata,
        .cpu_aff, .cpu_present, .spi_tgt, .spi_tgt_vld, .cpu_spi_map, .route_upd
    );

    typedef struct {
        int          kind;   // 0 rdata, 1 tgt, 2 vld, 3 map, 4 upd
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t       sb[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] tbl   [NC];
    logic [31:0] m_aff [NS];
    logic [7:0]  m_tgt [NS];
    logic [NS-1:0] m_map [NC];

    function automatic int owner(input logic [31:0] key);
        for (int c = 0; c < NC; c++)
            if (cpu_present[c] && tbl[c] == key) return c;
        return -1;
    endfunction

    function automatic logic [31:0] actual(input item_t it);
        case (it.kind)
            0: return acc_rdata;
            1: return 32'(spi_tgt[it.idx*8 +: 8]);
            2: return 32'(spi_tgt_vld[it.idx]);
            3: return 32'(cpu_spi_map[it.idx*NS +: NS]);
            default: return 32'(route_upd);
        endcase
    endfunction

    // Monitor: compare every expected item at the negedge after it was queued
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = actual(it);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                         it.req, it.kind, it.idx, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input int idx, input logic [31:0] exp, input string req);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic push_state(input string req);
        for (int s = 0; s < NS; s++) begin
            push(1, s, 32'(m_tgt[s]), req);
            push(2, s, 32'(m_tgt[s] != 8'hFF), req);
        end
        for (int c = 0; c < NC; c++) push(3, c, 32'(m_map[c]), req);
    endtask

    // Driver: applies one access cycle and queues the expected outcome
    task automatic op(input logic en, input logic we, input int addr,
                      input logic [31:0] data, input string req, input bit snap);
        int  num;
        bit  ok;
        int  s;
        @(negedge clk); #1;
        acc_en = en; acc_we = we; acc_addr = AW'(addr); acc_wdata = data;
        num = addr >> 1;
        ok  = (num >= 32) && (num < 32 + NS) && ((addr & 1) == 0);
        s   = num - 32;
        if (en && we && ok) begin
            int o, n;
            o = owner(m_aff[s]);
            if (o >= 0) m_map[o][s] = 1'b0;
            m_aff[s] = {8'h00, data[23:0]};
            n = owner(m_aff[s]);
            if (n >= 0) begin m_tgt[s] = 8'(n); m_map[n][s] = 1'b1; end
            else m_tgt[s] = 8'hFF;
        end
        push(4, 0, 32'(en && we && ok), "R9");
        if (en && !we) push(0, 0, ok ? {8'h00, m_aff[s][23:0]} : 32'h0, req);
        if (en && we) push(0, 0, 32'h0, "R10");
        if (snap) push_state(req);
    endtask

    task automatic rd(input int addr, input string req);
        op(1'b1, 1'b0, addr, 32'h0, req, 1'b0);
    endtask

    task automatic wr(input int addr, input logic [31:0] data, input string req);
        op(1'b1, 1'b1, addr, data, req, 1'b1);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tbl[0] = 32'h0000_0100;
        tbl[1] = 32'h0000_0101;
        tbl[2] = 32'h0002_0000;   // slot absent
        tbl[3] = 32'h0000_0101;   // duplicate of slot 1
        cpu_present = 4'b1011;
        for (int c = 0; c < NC; c++) cpu_aff[c*32 +: 32] = tbl[c];
        acc_en = 0; acc_we = 0; acc_addr = '0; acc_wdata = '0;
        rst_n = 0;
        for (int s = 0; s < NS; s++) begin m_aff[s] = tbl[0]; m_tgt[s] = 8'h00; end
        for (int c = 0; c < NC; c++) m_map[c] = (c == 0) ? '1 : '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst_n = 1;

        op(1'b0, 1'b0, 0, 32'h0, "R4", 1'b1);                  // reset image
        for (int s = 0; s < NS; s++) rd(64 + 2*s, "R4");
        rd(65, "R2");
        rd(79, "R2");
        op(1'b0, 1'b1, 64, 32'h0000_0101, "R10", 1'b1);        // no request: ignored

        wr(64, 32'h0000_0101, "R7");                           // spi0 -> slot1, leaves slot0
        rd(64, "R3");
        wr(66, 32'hAB00_0101, "R3");                           // top byte dropped
        rd(66, "R3");
        wr(68, 32'h0002_0000, "R8");                           // absent slot
        rd(68, "R3");
        wr(70, 32'h00FF_FFFF, "R6");                           // matches nothing
        rd(70, "R6");
        wr(68, 32'h0000_0100, "R5");                           // unowned -> slot0
        wr(64, 32'h0000_0100, "R7");                           // slot1 -> slot0
        wr(72, 32'h0000_0101, "R5");                           // duplicate: lowest slot wins

        wr(67, 32'hFFFF_FFFF, "R2");                           // upper word ignored
        rd(67, "R2");
        wr(62, 32'h0000_0101, "R1");                           // number 31
        wr(80, 32'h0000_0101, "R1");                           // number 40
        rd(62, "R1");
        rd(80, "R1");
        wr(78, 32'h0000_0101, "R1");                           // last routed number 39
        rd(78, "R1");
        wr(78, 32'h0012_3456, "R6");
        rd(78, "R3");
        wr(70, 32'h0000_0101, "R5");                           // unowned -> slot1

        op(1'b0, 1'b0, 0, 32'h0, "R9", 1'b1);
        op(1'b0, 1'b0, 0, 32'h0, "R9", 1'b0);
        @(negedge clk); #1;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R9 scoreboard actual=%0d expected=0", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule